// File: doc/BRIEF.md
# Pixel Select and Gating Register Bank

This block holds the peripheral registers that steer the configuration wires of a pixel matrix split into 32 regions. Each region owns four 16-bit registers: two column-select slices, a row-select slice and a pulse-gating slice. A control port presents a 16-bit address and a 16-bit data word. The address is not a plain index. Its low bits form a bitmap of the registers to touch. Two modifier bits widen a write to every region or turn it into a bitwise inversion. One transaction can therefore rewrite many registers across the whole bank.

The register contents are presented as three flat vectors. The first is a 1024-bit column-select vector. The other two are 512-bit vectors for row select and pulse gating. A read names a single register and returns its contents one cycle later, together with an error flag for malformed reads.

Top module: `pixsel_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every slice register, `rd_data` and `rd_err`.
- R2: An access targets the bank only when address bits 10:8 equal 3'b100. A write with any other value there changes no register.
- R3: Without broadcast, a write reaches only the region given by address bits 15:11. All other regions keep their contents.
- R4: When address bit 7 is set on a write, the chosen registers of all regions are written in the same cycle and bits 15:11 are ignored. A read ignores bit 7 and uses bits 15:11.
- R5: Address bits 0, 1, 2 and 3 pick column slice 1, column slice 2, the row slice and the gating slice. Any combination of these bits may be set in one write, and every picked register updates at the same clock edge.
- R6: When address bit 4 is set on a write, each picked column or row slice loads the bitwise complement of its current value, and the data word is ignored for those slices. A picked gating slice loads the data word exactly as it would without bit 4.
- R7: Register bit k of region r appears on the outputs as follows. Column slice 1 drives `col_sel[32r+k]` and column slice 2 drives `col_sel[32r+16+k]`. The row slice drives `row_sel[16r+k]` and the gating slice drives `gate_sel[16r+k]`. The new value is visible right after the write edge.
- R8: A read with a valid base field and exactly one of bits 3:0 set returns the picked register of region 15:11 on `rd_data`, with `rd_err` low, from the edge after the request. Both outputs hold until the next read.
- R9: A read whose bits 3:0 are not one-hot, or whose base field is wrong, returns 16'h0000 with `rd_err` high.
- R10: Address bits 6 and 5 have no effect on reads or writes.
- R11: A broadcast write with toggle clear, bits 3:0 all set and data 16'h0000 clears every select and gating register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Region field, base field, modifiers and register bitmap |
| req_wdata | input | 16 | Write data word |
| rd_data | output | 16 | Read result, registered |
| rd_err | output | 1 | Last read was malformed |
| col_sel | output | 1024 | Column-select lines, 32 per region |
| row_sel | output | 512 | Row-select lines, 16 per region |
| gate_sel | output | 512 | Pulse-gating lines, 16 per region |

## Verification
Every register drives output lines directly, so a wrong stored value shows up on `col_sel`, `row_sel` or `gate_sel` right after the write edge that caused it. The bench keeps its own copy of all 128 registers and compares the three whole vectors after every transaction. A write that lands in the wrong region or slice, a toggle applied to the gating slice, or a lost broadcast therefore shows up at once, and the bench does not depend on a later read to find it. Read errors appear on `rd_data` and `rd_err` one cycle after the request, and they stay visible until the next read.

// File: rtl/pixsel_bank.sv
module pixsel_bank #(
  parameter int NREG = 32,
  parameter int SW   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [15:0]           req_addr,
  input  logic [SW-1:0]         req_wdata,
  output logic [SW-1:0]         rd_data,
  output logic                  rd_err,
  output logic [2*SW*NREG-1:0]  col_sel,
  output logic [SW*NREG-1:0]    row_sel,
  output logic [SW*NREG-1:0]    gate_sel
);
  localparam logic [2:0] BASE = 3'b100;

  logic [4:0] reg_f;
  logic       base_ok, bcast, toggle, wr, rd, reg_ok;
  logic [3:0] pick;
  logic       unused_bits;

  assign reg_f       = req_addr[15:11];
  assign base_ok     = req_addr[10:8] == BASE;
  assign bcast       = req_addr[7];
  assign toggle      = req_addr[4];
  assign pick        = req_addr[3:0];
  assign unused_bits = ^req_addr[6:5];
  assign wr          = req_valid && req_write && base_ok;
  assign rd          = req_valid && !req_write;
  assign reg_ok      = 32'(reg_f) < NREG;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [SW-1:0] c1, c2, rs, pg;
    logic          hit;
    assign hit = wr && (bcast || reg_f == 5'(r));

    always_ff @(posedge clk) begin
      if (rst) begin
        c1 <= '0; c2 <= '0; rs <= '0; pg <= '0;
      end else if (hit) begin
        if (pick[0]) c1 <= toggle ? ~c1 : req_wdata;
        if (pick[1]) c2 <= toggle ? ~c2 : req_wdata;
        if (pick[2]) rs <= toggle ? ~rs : req_wdata;
        if (pick[3]) pg <= req_wdata;
      end
    end

    assign col_sel[2*SW*r +: SW]      = c1;
    assign col_sel[2*SW*r + SW +: SW] = c2;
    assign row_sel[SW*r +: SW]        = rs;
    assign gate_sel[SW*r +: SW]       = pg;
  end

  logic [SW-1:0] rd_next;
  logic          rd_bad;

  always_comb begin
    rd_next = '0;
    rd_bad  = 1'b1;
    if (base_ok && reg_ok && $onehot(pick)) begin
      rd_bad = 1'b0;
      case (pick)
        4'b0001: rd_next = col_sel[int'(reg_f)*2*SW +: SW];
        4'b0010: rd_next = col_sel[int'(reg_f)*2*SW + SW +: SW];
        4'b0100: rd_next = row_sel[int'(reg_f)*SW +: SW];
        default: rd_next = gate_sel[int'(reg_f)*SW +: SW];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else if (rd) begin
      rd_data <= rd_next;
      rd_err  <= rd_bad;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (col_sel == '0 && row_sel == '0 && gate_sel == '0 && rd_data == '0 && !rd_err)); // R1
  AST_BAD_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[10:8] != 3'b100) |=>
      ($stable(col_sel) && $stable(row_sel) && $stable(gate_sel))); // R2
  AST_TOGGLE_INVERT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[10:8] == 3'b100 && req_addr[4] && req_addr[0] &&
     (req_addr[7] || req_addr[15:11] == 5'd0)) |=>
      (col_sel[SW-1:0] == ~$past(col_sel[SW-1:0]))); // R6
  AST_TOGGLE_GATE_DATA: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[10:8] == 3'b100 && req_addr[4] && req_addr[3] &&
     (req_addr[7] || req_addr[15:11] == 5'd0)) |=>
      (gate_sel[SW-1:0] == $past(req_wdata))); // R6
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> ($stable(rd_data) && $stable(rd_err))); // R8
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> rd_data == '0); // R9
endmodule

// File: tb/pixsel_bank_bench.sv
module pixsel_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [15:0] rd_data;
  logic rd_err;
  logic [1023:0] col_sel;
  logic [511:0] row_sel, gate_sel;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_c1[NR], m_c2[NR], m_rs[NR], m_pg[NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  pixsel_bank u_pixsel_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .rd_err(rd_err),
    .col_sel(col_sel), .row_sel(row_sel), .gate_sel(gate_sel));

  function automatic logic [15:0] mk(input int rg, input bit bc, input bit tg,
                                     input logic [3:0] pk, input logic [2:0] base = 3'b100,
                                     input logic [1:0] sp = 2'b00);
    return {5'(rg), base, bc, sp, tg, pk};
  endfunction

  task automatic chk(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < NR; r++) begin m_c1[r] = 0; m_c2[r] = 0; m_rs[r] = 0; m_pg[r] = 0; end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [15:0] d);
    if (a[10:8] != 3'b100) return;
    for (int r = 0; r < NR; r++)
      if (a[7] || a[15:11] == 5'(r)) begin
        if (a[0]) m_c1[r] = a[4] ? ~m_c1[r] : d;
        if (a[1]) m_c2[r] = a[4] ? ~m_c2[r] : d;
        if (a[2]) m_rs[r] = a[4] ? ~m_rs[r] : d;
        if (a[3]) m_pg[r] = d;
      end
  endtask

  task automatic check_vecs(input string req);
    logic [1023:0] ec;
    logic [511:0] er, eg;
    for (int r = 0; r < NR; r++) begin
      ec[32*r +: 16] = m_c1[r];
      ec[32*r+16 +: 16] = m_c2[r];
      er[16*r +: 16] = m_rs[r];
      eg[16*r +: 16] = m_pg[r];
    end
    chk({req, " col"}, col_sel, ec);
    chk({req, " row"}, 1024'(row_sel), 1024'(er));
    chk({req, " gate"}, 1024'(gate_sel), 1024'(eg));
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [15:0] exp_d, input bit exp_e,
                         input string req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_valid = 0;
    chk({req, " rd_data"}, 1024'(rd_data), 1024'(exp_d));
    chk({req, " rd_err"}, 1024'(rd_err), 1024'(exp_e));
  endtask

  task automatic t_reset();
    model_clear();
    check_vecs("R1 reset");
    chk("R1 rd_data", 1024'(rd_data), 0);
    chk("R1 rd_err", 1024'(rd_err), 0);
  endtask

  task automatic t_single_region();
    do_write(mk(3, 0, 0, 4'b0001), 16'hA5A5);
    check_vecs("R3 single region");
    chk("R7 col bit 96", 1024'(col_sel[96]), 1);
    chk("R7 col bit 97", 1024'(col_sel[97]), 0);
  endtask

  task automatic t_multi();
    do_write(mk(5, 0, 0, 4'b1111), 16'h1357);
    check_vecs("R5 multi select");
    chk("R7 row slice r5", 1024'(row_sel[80 +: 16]), 1024'(16'h1357));
    chk("R7 col slice2 r5", 1024'(col_sel[176 +: 16]), 1024'(16'h1357));
  endtask

  task automatic t_broadcast();
    do_write(mk(7, 1, 0, 4'b0100), 16'h00F0);
    check_vecs("R4 broadcast");
    chk("R4 row r31", 1024'(row_sel[496 +: 16]), 1024'(16'h00F0));
  endtask

  task automatic t_toggle();
    do_write(mk(3, 0, 1, 4'b1011), 16'h1234);
    check_vecs("R6 toggle");
    chk("R6 c1 r3 inverted", 1024'(col_sel[96 +: 16]), 1024'(16'h5A5A));
    chk("R6 gate r3 data", 1024'(gate_sel[48 +: 16]), 1024'(16'h1234));
  endtask

  task automatic t_bad_base();
    do_write(mk(3, 1, 0, 4'b1111, 3'b101), 16'hFFFF);
    check_vecs("R2 bad base write");
    do_write(mk(9, 0, 0, 4'b0010, 3'b000), 16'hBEEF);
    check_vecs("R2 zero base write");
  endtask

  task automatic t_spare_bits();
    do_write(mk(11, 0, 0, 4'b1000, 3'b100, 2'b11), 16'h4242);
    check_vecs("R10 spare bits write");
    do_read(mk(11, 0, 0, 4'b1000, 3'b100, 2'b11), 16'h4242, 0, "R10 spare bits read");
  endtask

  task automatic t_reads();
    do_read(mk(3, 0, 0, 4'b0001), m_c1[3], 0, "R8 read c1 r3");
    do_read(mk(5, 1, 0, 4'b1000), m_pg[5], 0, "R4 read ignores broadcast");
    do_read(mk(20, 0, 0, 4'b0100), m_rs[20], 0, "R8 read row r20");
    repeat (3) @(negedge clk);
    chk("R8 read hold", 1024'(rd_data), 1024'(m_rs[20]));
    do_read(mk(5, 0, 0, 4'b0011), 16'h0000, 1, "R9 multi-hot read");
    do_read(mk(5, 0, 0, 4'b0000), 16'h0000, 1, "R9 empty read");
    do_read(mk(5, 0, 0, 4'b0001, 3'b110), 16'h0000, 1, "R9 bad base read");
    do_read(mk(5, 0, 0, 4'b0010), m_c2[5], 0, "R9 good read clears error");
  endtask

  task automatic t_clear_all();
    do_write(mk(0, 1, 1, 4'b0111), 16'h0000);
    check_vecs("R6 broadcast toggle");
    do_write(mk(0, 1, 0, 4'b1111), 16'h0000);
    check_vecs("R11 clear all");
    chk("R11 col zero", col_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_single_region();
    t_multi();
    t_broadcast();
    t_toggle();
    t_bad_base();
    t_spare_bits();
    t_reads();
    t_clear_all();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule